// File: doc/BRIEF.md
# In-Order Target Response Generator

This block sits behind the receive side of a packet endpoint. It takes target request packets as a 64-bit stream in which the first beat of every packet is a header and any later beats carry payload. It looks at the format and transaction-kind fields of each header. Only two kinds ask for a reply: a read request, and a write that asks for a reply. For either of these it builds a response packet on a second 64-bit stream. Every other kind is taken in and dropped without a trace.

Each response header copies the request's transaction tag, carries the response format code, a "done" status and a priority one step above the request's. The priority stops at its top value and does not wrap. A read response is followed by data beats with a computed incrementing byte pattern. The number of data beats comes from the size field of the request.

Only one request is handled at a time, so responses leave in the order the requests arrived. Payload beats of a request are drained while its response is being sent. The next header is held off until that response has fully left.

Top module: `rg_target_responder`

## Requirements
- R1: A header whose format field (bits [55:52]) is 4'h2 and whose kind field (bits [51:48]) is 4'h4 (read), or whose format is 4'h5 and kind is 4'h5 (write with reply), produces exactly one response packet. Any other format/kind pair produces none.
- R2: Requests that need no reply, including format 4'h6 (streaming write) and format 4'h5 with kind 4'h4 (plain write), are consumed with no beat on the response stream.
- R3: Response header layout: bits [63:56] equal request bits [63:56] (transaction tag); [55:52] = 4'hD; [51:48] = 4'h8 for a read and 4'h0 for a write-with-reply; bit 47 = 0; bit 44 equals request bit 44; [43:36] equal request [43:36] for a read and 8'h00 otherwise; [35:32] (status) = 4'b0000 (done); [31:0] = 0.
- R4: Response priority bits [46:45] equal request bits [46:45] plus one, saturating at 2'b11.
- R5: A read response carries (request bits [43:39]) + 1 data beats after its header. rsp_last is high only on the final beat of each response (on the header itself for a write-with-reply), and rsp_keep is 8'hFF on every beat.
- R6: In data beat k (k counted from 0) of a read response, byte lane j (lane 0 at bits [63:56], lane 7 at bits [7:0]) holds (8*k + j) mod 256.
- R7: Request beats after the header up to and including the one marked with req_last are accepted and discarded. While no response is pending, req_ready is high.
- R8: While a response is pending and the request payload has been fully drained, req_ready is low. A response beat held by rsp_ready low stays valid and unchanged.
- R9: Responses leave in request arrival order. After the last beat of a response is taken, rsp_valid is low for at least one cycle.
- R10: During and right after reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Request beat accepted when high with req_valid |
| req_data | input | 64 | Request beat: header on the first beat, payload after |
| req_last | input | 1 | Final beat of the request packet |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Downstream takes the response beat |
| rsp_data | output | 64 | Response beat: header first, then read data |
| rsp_keep | output | 8 | Byte enables, all ones |
| rsp_last | output | 1 | Final beat of the response packet |

## Verification
Draining a request's payload and sending that request's response can happen in the same cycle: a write-with-reply header with several payload beats makes the reply header valid one cycle after acceptance, while the payload beats are still arriving. The bench drives both streams with independent throttle patterns and counts the cycles in which a payload beat and a response beat both hand off. It then judges every beat against a response list built arithmetically from the request list. It also checks that req_ready falls only after the payload has been drained, and that stalled response beats hold still.

// File: rtl/rg_pkg.sv
package rg_pkg;
    localparam int TDATA_W  = 64;
    localparam int LANE_W   = 8;
    localparam int LANES    = TDATA_W / LANE_W;
    localparam int SIZE_W   = 8;
    localparam int LANE_SH  = $clog2(LANES);
    localparam int BEAT_W   = SIZE_W - LANE_SH + 1;

    localparam logic [3:0] FMT_READ   = 4'h2;
    localparam logic [3:0] FMT_WRITE  = 4'h5;
    localparam logic [3:0] FMT_REPLY  = 4'hD;
    localparam logic [3:0] KIND_READ  = 4'h4;
    localparam logic [3:0] KIND_WRRSP = 4'h5;
    localparam logic [3:0] KIND_NODAT = 4'h0;
    localparam logic [3:0] KIND_DATA  = 4'h8;
    localparam logic [3:0] STAT_DONE  = 4'h0;

    typedef struct packed {
        logic                drain;
        logic                ovalid;
        logic [TDATA_W-1:0]  odata;
        logic                olast;
        logic [BEAT_W-1:0]   beat;
        logic [BEAT_W-1:0]   nbeats;
    } rg_state_t;
endpackage

// File: rtl/rg_hdr_decode.sv
module rg_hdr_decode
    import rg_pkg::*;
(
    input  logic [TDATA_W-1:0] hdr,
    output logic               need_reply,
    output logic               is_read,
    output logic [TDATA_W-1:0] rsp_hdr,
    output logic [BEAT_W-1:0]  nbeats
);
    logic [7:0]        tag;
    logic [3:0]        fmt;
    logic [3:0]        kind;
    logic [1:0]        prio;
    logic [1:0]        prio_up;
    logic              crf;
    logic [SIZE_W-1:0] size;
    logic              unused_hdr_bits;

    assign tag  = hdr[63:56];
    assign fmt  = hdr[55:52];
    assign kind = hdr[51:48];
    assign prio = hdr[46:45];
    assign crf  = hdr[44];
    assign size = hdr[43:36];
    assign unused_hdr_bits = ^{hdr[47], hdr[35:0]};

    always_comb begin
        is_read    = (fmt == FMT_READ)  && (kind == KIND_READ);
        need_reply = is_read || ((fmt == FMT_WRITE) && (kind == KIND_WRRSP));
        prio_up    = (prio == 2'b11) ? 2'b11 : prio + 2'b01;
        nbeats     = BEAT_W'(size >> LANE_SH) + BEAT_W'(1);
        rsp_hdr    = {tag, FMT_REPLY, (is_read ? KIND_DATA : KIND_NODAT),
                      1'b0, prio_up, crf, (is_read ? size : {SIZE_W{1'b0}}),
                      STAT_DONE, 32'h0};
    end
endmodule

// File: rtl/rg_fill.sv
module rg_fill
    import rg_pkg::*;
(
    input  logic [BEAT_W-1:0]  beat,
    output logic [TDATA_W-1:0] data
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign data[TDATA_W-1-LANE_W*j -: LANE_W] = LANE_W'(int'(beat) * LANES + j);
    end
endmodule

// File: rtl/rg_target_responder.sv
module rg_target_responder
    import rg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [TDATA_W-1:0]    req_data,
    input  logic                  req_last,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [TDATA_W-1:0]    rsp_data,
    output logic [LANES-1:0]      rsp_keep,
    output logic                  rsp_last
);
    rg_state_t q, n;

    logic               dec_reply;
    logic               dec_read;
    logic [TDATA_W-1:0] dec_rsp;
    logic [BEAT_W-1:0]  dec_beats;
    logic [TDATA_W-1:0] fill_data;

    rg_hdr_decode u_dec (
        .hdr        (req_data),
        .need_reply (dec_reply),
        .is_read    (dec_read),
        .rsp_hdr    (dec_rsp),
        .nbeats     (dec_beats)
    );

    rg_fill u_fill (
        .beat (q.beat),
        .data (fill_data)
    );

    // Payload may drain while a response is out; a new header waits for an idle output.
    assign req_ready = q.drain | ~q.ovalid;

    always_comb begin
        n = q;
        if (q.ovalid && rsp_ready) begin
            if (q.olast) begin
                n.ovalid = 1'b0;
            end else begin
                n.odata = fill_data;
                n.olast = (q.beat == q.nbeats - 1'b1);
                n.beat  = q.beat + 1'b1;
            end
        end
        if (req_valid && req_ready) begin
            n.drain = ~req_last;
            if (!q.drain && dec_reply) begin
                n.ovalid = 1'b1;
                n.odata  = dec_rsp;
                n.olast  = ~dec_read;
                n.beat   = '0;
                n.nbeats = dec_beats;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rsp_valid = q.ovalid;
    assign rsp_data  = q.odata;
    assign rsp_last  = q.olast;
    assign rsp_keep  = {LANES{1'b1}};

    // R8: a stalled response beat holds still
    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));

    // R9: one response at a time, a gap after each
    a_r9_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);

    // R3: a response opens with a reply header, caused by an accepted request beat
    a_r3_reply_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_data[55:52] == FMT_REPLY) && $past(req_valid && req_ready));

    // R5: a response is contiguous until its last beat
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !rsp_last |=> rsp_valid);

    // R7: after a non-final request beat the payload keeps draining
    a_r7_keep_draining: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_last |=> req_ready);
endmodule

// File: tb/tb_rg_target_responder.sv
module tb_rg_target_responder;
    localparam int IN_MAX  = 4096;
    localparam int OUT_MAX = 16384;
    localparam int WD      = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_data;
    logic        req_last;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [63:0] rsp_data;
    logic [7:0]  rsp_keep;
    logic        rsp_last;

    always #10 clk = ~clk;

    rg_target_responder dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_keep(rsp_keep), .rsp_last(rsp_last)
    );

    logic [63:0] ib_d [0:IN_MAX-1];
    logic        ib_l [0:IN_MAX-1];
    logic [63:0] ex_d [0:OUT_MAX-1];
    logic        ex_l [0:OUT_MAX-1];
    logic        ex_h [0:OUT_MAX-1];
    int n_in = 0, n_exp = 0, n_rsp_exp = 0, first_reply_in = -1;
    int errs = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic add_req(input logic [7:0] tag, input logic [3:0] fmt, input logic [3:0] kind,
                           input logic [1:0] pr, input logic crf, input logic [7:0] sz, input int npay);
        bit rd, rep;
        logic [1:0] pu;
        int nb;
        rd  = (fmt == 4'h2) && (kind == 4'h4);
        rep = rd || ((fmt == 4'h5) && (kind == 4'h5));
        if (rep && first_reply_in < 0) first_reply_in = n_in;
        ib_d[n_in] = {tag, fmt, kind, tag[0], pr, crf, sz, 36'h987654321 ^ {28'h0, tag}};
        ib_l[n_in] = (npay == 0);
        n_in++;
        for (int p = 0; p < npay; p++) begin
            ib_d[n_in] = {tag, 8'hA5, 16'(p), 32'hDEADBEEF};
            ib_l[n_in] = (p == npay - 1);
            n_in++;
        end
        if (rep) begin
            pu = (pr == 2'b11) ? 2'b11 : pr + 2'b01;
            nb = int'(sz >> 3) + 1;
            n_rsp_exp++;
            ex_d[n_exp] = {tag, 4'hD, (rd ? 4'h8 : 4'h0), 1'b0, pu, crf, (rd ? sz : 8'h00), 36'h0};
            ex_l[n_exp] = !rd;
            ex_h[n_exp] = 1'b1;
            n_exp++;
            if (rd) begin
                for (int k = 0; k < nb; k++) begin
                    logic [63:0] w;
                    for (int j = 0; j < 8; j++) w[63-8*j -: 8] = 8'((8*k + j) % 256);
                    ex_d[n_exp] = w;
                    ex_l[n_exp] = (k == nb - 1);
                    ex_h[n_exp] = 1'b0;
                    n_exp++;
                end
            end
        end
    endtask

    initial begin
        int cyc, ip, op, overlap, rsp_seen;
        bit hdr_next, prev_stall, prev_l, done;
        logic [63:0] prev_d;

        // sweep of every format/kind pair, plain writes and streaming writes among them
        for (int f = 0; f < 16; f++)
            for (int t = 0; t < 16; t++)
                add_req(8'(f*16 + t), 4'(f), 4'(t), 2'(t), 1'(f), 8'(t*16 + f), (f + t) % 3);
        // reads over every size value
        for (int s = 0; s < 256; s++)
            add_req(8'(s), 4'h2, 4'h4, 2'(s), 1'(s >> 2), 8'(s), s % 2);
        // write-with-reply over priorities and payload lengths, with drops between
        for (int i = 0; i < 16; i++) begin
            add_req(8'(8'h30 + i), 4'h5, 4'h5, 2'(i), 1'(i >> 2), 8'(i), i % 4);
            add_req(8'(8'h60 + i), 4'h6, 4'(i), 2'(i), 1'b0, 8'h07, 1);
        end

        rst_n = 1'b0; req_valid = 1'b0; req_data = '0; req_last = 1'b0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        #9;
        chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", 64'(rsp_valid), 64'h0);
        chk(req_ready == 1'b1, "R10 req_ready in reset", 64'(req_ready), 64'h1);
        @(negedge clk);
        rst_n = 1'b1;
        #9;
        chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        chk(req_ready == 1'b1, "R10 req_ready after reset", 64'(req_ready), 64'h1);

        cyc = 0; ip = 0; op = 0; overlap = 0; rsp_seen = 0;
        hdr_next = 1'b1; prev_stall = 1'b0; prev_l = 1'b0; prev_d = '0; done = 1'b0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            req_valid = (ip < n_in) && ((cyc % 7) != 5);
            req_data  = (ip < n_in) ? ib_d[ip] : 64'h0;
            req_last  = (ip < n_in) ? ib_l[ip] : 1'b0;
            rsp_ready = !((cyc % 97) < 30) && (((cyc % 3) != 1) || cyc[10]);
            #9;
            if (prev_stall)
                chk(rsp_valid && rsp_data == prev_d && rsp_last == prev_l,
                    "R8 stalled beat held", rsp_data, prev_d);
            if (rsp_valid && hdr_next)
                chk(req_ready == 1'b0, "R8 header held off while reply pending", 64'(req_ready), 64'h0);
            if (!rsp_valid)
                chk(req_ready == 1'b1, "R7 ready with no reply pending", 64'(req_ready), 64'h1);
            if (req_valid && req_ready && !hdr_next && rsp_valid && rsp_ready) overlap++;
            if (rsp_valid && rsp_ready) begin
                if (op == 0)
                    chk(ip > first_reply_in, "R2 no output before first replying request",
                        64'(ip), 64'(first_reply_in + 1));
                if (op >= n_exp) begin
                    chk(1'b0, "R9 extra response beat", rsp_data, 64'h0);
                end else begin
                    if (ex_h[op]) begin
                        rsp_seen++;
                        chk(rsp_data[63:48] == ex_d[op][63:48], "R9 response order, tag and kind",
                            64'(rsp_data[63:48]), 64'(ex_d[op][63:48]));
                        chk(rsp_data[46:45] == ex_d[op][46:45], "R4 priority step",
                            64'(rsp_data[46:45]), 64'(ex_d[op][46:45]));
                        chk(rsp_data == ex_d[op], "R3 response header", rsp_data, ex_d[op]);
                    end else begin
                        chk(rsp_data == ex_d[op], "R6 read fill pattern", rsp_data, ex_d[op]);
                    end
                    chk(rsp_last == ex_l[op], "R5 last flag", 64'(rsp_last), 64'(ex_l[op]));
                    chk(rsp_keep == 8'hFF, "R5 keep all ones", 64'(rsp_keep), 64'hFF);
                end
                op++;
            end
            if (req_valid && req_ready) begin
                hdr_next = req_last;
                ip++;
            end
            prev_stall = rsp_valid && !rsp_ready;
            prev_d = rsp_data;
            prev_l = rsp_last;
            if (ip == n_in && op == n_exp) done = 1'b1;
            if (cyc > WD) begin
                chk(1'b0, "R9 watchdog expired", 64'(op), 64'(n_exp));
                done = 1'b1;
            end
        end

        rsp_ready = 1'b1;
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #9;
            chk(rsp_valid == 1'b0, "R2 no stray output after stream", 64'(rsp_valid), 64'h0);
        end
        chk(ip == n_in, "R7 all request beats consumed", 64'(ip), 64'(n_in));
        chk(rsp_seen == n_rsp_exp, "R1 response count", 64'(rsp_seen), 64'(n_rsp_exp));
        chk(overlap > 0, "R7 payload drained alongside response", 64'(overlap), 64'h1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule